// File: doc/BRIEF.md
# Multi-Mode Host Bus Front End

This block is the host-facing entry point of a display controller. A host processor reaches the controller's registers through one of several bus styles. A three-pin strap picks the style: an enable-strobe parallel bus (direction given by a level line), a dual-strobe parallel bus (separate write and read strobes), each in 16-bit or 8-bit width, or a clock-synchronous serial link. Whatever the strap, the block presents the rest of the chip with a single stream of one-cycle events. These are an index write, a control-data write and a read request. The register file answers a read request with a 16-bit word.

Every host pin is brought into the system clock through two-flop synchronizers, and the strobe edges are found in that domain. A register-select line splits each access in two. When it is low, a write loads the index and a read returns status. When it is high, the access targets control data. In 8-bit widths a word travels as two byte transfers on the upper lanes, upper byte first. The serial link frames each word behind a start byte that carries a device-ID bit taken from the strap. A frame whose ID does not match is discarded. Read data leaves the block on a split pad interface (data out, lane-group enables), which the pad ring combines with the input lanes.

Top module: `host_bus_front`

## Requirements
- R1: Strap `mode_sel` decodes as 000 = enable-strobe 16-bit, 001 = enable-strobe 8-bit, 010 = dual-strobe 16-bit, 011 = dual-strobe 8-bit, 10x = serial, 11x = disabled. In disabled mode, and in any mode for the interface style not selected, no write pulse, read request or bus drive is produced.
- R2: After reset, and whenever chip select `cs_n` is high, strobes have no effect and both `db_oe_hi` and `db_oe_lo` stay low.
- R3: With `rs` low a write produces `idx_we` and a read produces `rd_req` with `rd_rs` low (status). With `rs` high a write produces `ctl_we` and a read produces `rd_req` with `rd_rs` high.
- R4: In enable-strobe modes, `rw_rd` low marks a write and high marks a read. The write completes on the falling edge of the enable (`stb_sclk`), carrying the bus value seen while the enable was high.
- R5: In dual-strobe modes, `stb_sclk` is an active-low write strobe and `rw_rd` is an active-low read strobe. Write data is taken while the write strobe is low and committed when it rises.
- R6: A 16-bit read raises `rd_req` for one cycle at the start of the read strobe. `rdata` is captured in that cycle and driven on all 16 lanes of `db_o` with both enables high until the strobe ends.
- R7: In 8-bit modes only lanes 15..8 carry data. Lanes 7..0 are ignored on writes and never enabled on reads. The first byte of a word is bits 15..8 and the second is bits 7..0. A read issues one `rd_req` for the pair.
- R8: In 8-bit modes, a byte whose `rs` or direction differs from a pending first byte starts a new pair as a first byte. After an index write completes, the next byte is always a first byte.
- R9: In serial mode, `db_i[0]` is sampled on each rising edge of `stb_sclk` while `cs_n` is low. A start byte of pattern 01110, ID bit, RS bit and R/W bit (sent in that order) is followed by 16 data bits, MSB first. Together they give one write pulse with the word.
- R10: A serial frame whose ID bit differs from `mode_sel[0]`, or whose R/W bit is 1, produces nothing until `cs_n` goes high.
- R11: In serial mode, further groups of 16 bits under the same chip select each give another write with the same RS. Raising `cs_n` discards a partial frame.
- R12: Every `idx_we`, `ctl_we` and `rd_req` pulse lasts exactly one clock cycle, and `idx_we` and `ctl_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Interface strap; bit 0 is the device ID in serial mode |
| cs_n | input | 1 | Active-low chip select |
| rs | input | 1 | Register select: 0 index/status, 1 control |
| stb_sclk | input | 1 | Enable strobe, active-low write strobe, or serial clock |
| rw_rd | input | 1 | Direction level (1 = read), or active-low read strobe |
| db_i | input | 16 | Data lanes from the pad; bit 0 is serial data in |
| db_o | output | 16 | Read data toward the pad |
| db_oe_hi | output | 1 | Drive enable for lanes 15..8 |
| db_oe_lo | output | 1 | Drive enable for lanes 7..0 |
| idx_we | output | 1 | One-cycle index write pulse |
| ctl_we | output | 1 | One-cycle control-data write pulse |
| wdata | output | 16 | Write word, valid with a write pulse |
| rd_req | output | 1 | One-cycle read request |
| rd_rs | output | 1 | Register select of the latest read request |
| rdata | input | 16 | Read word, valid in the cycle `rd_req` is high |

## Verification
The embedded assertions watch, on every cycle, the following: the one-cycle width and mutual exclusion of the write pulses, the single-cycle read request, and the bus released after chip select rises. They also check that the unselected front end stays quiet, that 8-bit modes never enable the low lanes, and that the serial receiver restarts when chip select is high. The correctness of the data itself can only be shown by the bench's directed scenarios. This covers byte ordering and pair restart in 8-bit widths, the register-select split, the serial start-byte filtering and burst continuation, and the exact read word on the lanes.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [2:0] {
        HM_E_16   = 3'd0,
        HM_E_8    = 3'd1,
        HM_DS_16  = 3'd2,
        HM_DS_8   = 3'd3,
        HM_SERIAL = 3'd4,
        HM_OFF    = 3'd5
    } host_mode_e;

    function automatic host_mode_e decode_mode(input logic [2:0] strap);
        case (strap)
            3'b000:        return HM_E_16;
            3'b001:        return HM_E_8;
            3'b010:        return HM_DS_16;
            3'b011:        return HM_DS_8;
            3'b100, 3'b101: return HM_SERIAL;
            default:       return HM_OFF;
        endcase
    endfunction

    localparam int SER_HDR_W = 8;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/hbi_par.sv
module hbi_par #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dual_stb,
    input  logic          narrow,
    input  logic          cs_n,
    input  logic          rs,
    input  logic          stb,
    input  logic          rw,
    input  logic [DW-1:0] db,
    input  logic [DW-1:0] rdata,
    output logic          idx_we,
    output logic          ctl_we,
    output logic [DW-1:0] wdata,
    output logic          rd_req,
    output logic          rd_rs,
    output logic [DW-1:0] dout,
    output logic          oe_hi,
    output logic          oe_lo
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int HW = DW / 2;

    typedef struct packed {
        logic          act;
        logic          cap_rs;
        logic          cap_rd;
        logic [DW-1:0] cap_db;
        logic          phase;
        logic          first_rs;
        logic          first_rd;
        logic [HW-1:0] hi_byte;
        logic          sel_lo;
        logic          fetch;
        logic          drv;
        logic [DW-1:0] hold;
        logic          idx_we;
        logic          ctl_we;
        logic [DW-1:0] wdata;
        logic          rd_req;
        logic          rd_rs;
    } par_st_t;

    par_st_t st_d, st_q;
    logic    sel, act_now, rd_now, start_ev, fin_ev, pair_hit_rd, pair_hit_wr;

    always_comb begin
        sel         = en & ~cs_n;
        act_now     = dual_stb ? (~stb | ~rw) : stb;
        rd_now      = dual_stb ? ~rw : rw;
        start_ev    = sel & act_now & ~st_q.act;
        fin_ev      = sel & ~act_now & st_q.act;
        pair_hit_rd = narrow & st_q.phase & st_q.first_rd & (st_q.first_rs == rs);
        pair_hit_wr = st_q.phase & ~st_q.first_rd & (st_q.first_rs == st_q.cap_rs);

        st_d        = st_q;
        st_d.idx_we = 1'b0;
        st_d.ctl_we = 1'b0;
        st_d.rd_req = 1'b0;

        if (!sel) begin
            st_d.act   = 1'b0;
            st_d.drv   = 1'b0;
            st_d.fetch = 1'b0;
        end else begin
            st_d.act = act_now;
            if (act_now) begin
                st_d.cap_rs = rs;
                st_d.cap_rd = rd_now;
                st_d.cap_db = db;
            end
            if (start_ev && rd_now) begin
                if (pair_hit_rd) begin
                    st_d.sel_lo = 1'b1;
                    st_d.drv    = 1'b1;
                end else begin
                    st_d.sel_lo = 1'b0;
                    st_d.rd_req = 1'b1;
                    st_d.rd_rs  = rs;
                    st_d.fetch  = 1'b1;
                    st_d.drv    = 1'b0;
                end
            end
            if (st_q.fetch) begin
                st_d.hold  = rdata;
                st_d.fetch = 1'b0;
                st_d.drv   = 1'b1;
            end
            if (fin_ev) begin
                st_d.drv   = 1'b0;
                st_d.fetch = 1'b0;
                if (st_q.cap_rd) begin
                    if (narrow) begin
                        st_d.phase    = ~st_q.sel_lo;
                        st_d.first_rd = 1'b1;
                        st_d.first_rs = st_q.cap_rs;
                    end
                end else if (!narrow) begin
                    st_d.wdata  = st_q.cap_db;
                    st_d.idx_we = ~st_q.cap_rs;
                    st_d.ctl_we = st_q.cap_rs;
                end else if (pair_hit_wr) begin
                    st_d.wdata  = {st_q.hi_byte, st_q.cap_db[DW-1:HW]};
                    st_d.idx_we = ~st_q.cap_rs;
                    st_d.ctl_we = st_q.cap_rs;
                    st_d.phase  = 1'b0;
                end else begin
                    st_d.hi_byte  = st_q.cap_db[DW-1:HW];
                    st_d.phase    = 1'b1;
                    st_d.first_rd = 1'b0;
                    st_d.first_rs = st_q.cap_rs;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_we = st_q.idx_we;
    assign ctl_we = st_q.ctl_we;
    assign wdata  = st_q.wdata;
    assign rd_req = st_q.rd_req;
    assign rd_rs  = st_q.rd_rs;
    assign oe_hi  = st_q.drv;
    assign oe_lo  = st_q.drv & ~narrow;
    assign dout   = narrow ? {(st_q.sel_lo ? st_q.hold[HW-1:0] : st_q.hold[DW-1:HW]), {HW{1'b0}}}
                           : st_q.hold;

    AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_we && ctl_we)); // R12
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we || ctl_we) |=> !(idx_we || ctl_we)); // R12
    AST_RDREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R6
    AST_CS_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !(oe_hi || oe_lo)); // R2
    AST_NARROW_LOW_LANES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && $stable(narrow)) |-> !oe_lo); // R7
endmodule

// File: rtl/hbi_ser.sv
module hbi_ser
    import hbi_pkg::*;
#(
    parameter int         DW      = 16,
    parameter logic [4:0] SER_PAT = 5'b01110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dev_id,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          sdi,
    output logic          idx_we,
    output logic          ctl_we,
    output logic [DW-1:0] wdata
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW = $clog2(SER_HDR_W + DW);

    typedef struct packed {
        logic          sclk_prev;
        logic [CW-1:0] cnt;
        logic          drop;
        logic          rs;
        logic [DW-2:0] sh;
        logic          idx_we;
        logic          ctl_we;
        logic [DW-1:0] wdata;
    } ser_st_t;

    ser_st_t       st_d, st_q;
    logic [DW-1:0] nxt;
    logic          rise;

    always_comb begin
        st_d           = st_q;
        st_d.idx_we    = 1'b0;
        st_d.ctl_we    = 1'b0;
        st_d.sclk_prev = sclk;
        nxt            = {st_q.sh, sdi};
        rise           = sclk & ~st_q.sclk_prev;

        if (!en || cs_n) begin
            st_d.cnt  = '0;
            st_d.drop = 1'b0;
        end else if (rise && !st_q.drop) begin
            st_d.sh = nxt[DW-2:0];
            if (st_q.cnt == CW'(SER_HDR_W - 1)) begin
                if (nxt[7:3] != SER_PAT || nxt[2] != dev_id || nxt[0]) begin
                    st_d.drop = 1'b1;
                end
                st_d.rs  = nxt[1];
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (st_q.cnt == CW'(SER_HDR_W + DW - 1)) begin
                st_d.wdata  = nxt;
                st_d.idx_we = ~st_q.rs;
                st_d.ctl_we = st_q.rs;
                st_d.cnt    = CW'(SER_HDR_W);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_we = st_q.idx_we;
    assign ctl_we = st_q.ctl_we;
    assign wdata  = st_q.wdata;

    AST_SER_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we || ctl_we) |-> (st_q.cnt == CW'(SER_HDR_W))); // R11
    AST_SER_CS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !en) |=> (st_q.cnt == '0 && !st_q.drop)); // R11
    AST_SER_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.drop && $past(st_q.drop)) |-> !(idx_we || ctl_we)); // R10
endmodule

// File: rtl/host_bus_front.sv
module host_bus_front
    import hbi_pkg::*;
#(
    parameter int         DW      = 16,
    parameter int         SYNC_N  = 2,
    parameter logic [4:0] SER_PAT = 5'b01110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_sel,
    input  logic          cs_n,
    input  logic          rs,
    input  logic          stb_sclk,
    input  logic          rw_rd,
    input  logic [DW-1:0] db_i,
    output logic [DW-1:0] db_o,
    output logic          db_oe_hi,
    output logic          db_oe_lo,
    output logic          idx_we,
    output logic          ctl_we,
    output logic [DW-1:0] wdata,
    output logic          rd_req,
    output logic          rd_rs,
    input  logic [DW-1:0] rdata
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int SW = DW + 4;

    host_mode_e    mode;
    logic          par_en, dual_stb, narrow, ser_en;
    logic [SW-1:0] pins_s;
    logic          cs_s, rs_s, stb_s, rw_s;
    logic [DW-1:0] db_s;
    logic          p_idx, p_ctl, p_rd, s_idx, s_ctl;
    logic [DW-1:0] p_wdata, s_wdata;

    always_comb begin
        mode     = decode_mode(mode_sel);
        par_en   = (mode == HM_E_16) || (mode == HM_E_8) || (mode == HM_DS_16) || (mode == HM_DS_8);
        dual_stb = (mode == HM_DS_16) || (mode == HM_DS_8);
        narrow   = (mode == HM_E_8) || (mode == HM_DS_8);
        ser_en   = (mode == HM_SERIAL);
    end

    hbi_sync #(.W(SW), .STAGES(SYNC_N), .RST_VAL({SW{1'b1}})) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, rs, stb_sclk, rw_rd, db_i}),
        .dout (pins_s)
    );

    assign {cs_s, rs_s, stb_s, rw_s, db_s} = pins_s;

    hbi_par #(.DW(DW)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (par_en),
        .dual_stb(dual_stb),
        .narrow  (narrow),
        .cs_n    (cs_s),
        .rs      (rs_s),
        .stb     (stb_s),
        .rw      (rw_s),
        .db      (db_s),
        .rdata   (rdata),
        .idx_we  (p_idx),
        .ctl_we  (p_ctl),
        .wdata   (p_wdata),
        .rd_req  (p_rd),
        .rd_rs   (rd_rs),
        .dout    (db_o),
        .oe_hi   (db_oe_hi),
        .oe_lo   (db_oe_lo)
    );

    hbi_ser #(.DW(DW), .SER_PAT(SER_PAT)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ser_en),
        .dev_id(mode_sel[0]),
        .cs_n  (cs_s),
        .sclk  (stb_s),
        .sdi   (db_s[0]),
        .idx_we(s_idx),
        .ctl_we(s_ctl),
        .wdata (s_wdata)
    );

    assign idx_we = p_idx | s_idx;
    assign ctl_we = p_ctl | s_ctl;
    assign rd_req = p_rd;
    assign wdata  = (s_idx | s_ctl) ? s_wdata : p_wdata;

    AST_PAR_QUIET_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_en && $stable(mode_sel)) |-> !(p_idx || p_ctl || p_rd)); // R1
    AST_SER_QUIET_PAR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en && $stable(mode_sel)) |-> !(s_idx || s_ctl)); // R1
    AST_NO_DRIVE_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !par_en |=> !(db_oe_hi || db_oe_lo)); // R1
endmodule

// File: tb/host_bus_front_tb.sv
module host_bus_front_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'b000;
    logic        cs_n = 1'b1;
    logic        rs = 1'b0;
    logic        stb_sclk = 1'b0;
    logic        rw_rd = 1'b0;
    logic [15:0] db_i = 16'hFFFF;
    logic [15:0] db_o;
    logic        db_oe_hi, db_oe_lo;
    logic        idx_we, ctl_we, rd_req, rd_rs;
    logic [15:0] wdata, rdata;

    int          n_chk = 0;
    int          n_err = 0;
    int          n_idx = 0;
    int          n_ctl = 0;
    int          n_rd = 0;
    logic [15:0] last_w = '0;
    logic        is_ds = 1'b0;
    logic        done = 1'b0;

    localparam logic [15:0] STAT_VAL = 16'h5A0F;
    localparam logic [15:0] CTL_VAL  = 16'hC3A5;

    always #2.5 clk = ~clk;

    assign rdata = rd_rs ? CTL_VAL : STAT_VAL;

    host_bus_front u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .rs(rs),
        .stb_sclk(stb_sclk), .rw_rd(rw_rd), .db_i(db_i), .db_o(db_o),
        .db_oe_hi(db_oe_hi), .db_oe_lo(db_oe_lo), .idx_we(idx_we), .ctl_we(ctl_we),
        .wdata(wdata), .rd_req(rd_req), .rd_rs(rd_rs), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (idx_we) n_idx <= n_idx + 1;
        if (ctl_we) n_ctl <= n_ctl + 1;
        if (rd_req) n_rd <= n_rd + 1;
        if (idx_we || ctl_we) last_w <= wdata;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        cs_n     = 1'b1;
        mode_sel = m;
        is_ds    = (m[2:1] == 2'b01) || (m[2:1] == 2'b11);
        stb_sclk = is_ds ? 1'b1 : 1'b0;
        rw_rd    = is_ds ? 1'b1 : 1'b0;
        if (m[2] == 1'b1 && m[1] == 1'b0) stb_sclk = 1'b0;
        wait_clk(6);
    endtask

    task automatic bus_wr(input logic r, input logic [15:0] v, input logic csv);
        cs_n = csv;
        rs   = r;
        db_i = v;
        if (!is_ds) rw_rd = 1'b0;
        wait_clk(4);
        stb_sclk = is_ds ? 1'b0 : 1'b1;
        wait_clk(6);
        stb_sclk = is_ds ? 1'b1 : 1'b0;
        wait_clk(4);
        cs_n = 1'b1;
        db_i = 16'hFFFF;
        wait_clk(6);
    endtask

    task automatic bus_rd(input logic r, input logic csv, output logic [15:0] dat,
                          output logic oh, output logic ol);
        cs_n = csv;
        rs   = r;
        if (!is_ds) rw_rd = 1'b1;
        wait_clk(4);
        if (is_ds) rw_rd = 1'b0; else stb_sclk = 1'b1;
        wait_clk(8);
        dat = db_o;
        oh  = db_oe_hi;
        ol  = db_oe_lo;
        if (is_ds) rw_rd = 1'b1; else stb_sclk = 1'b0;
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic ser_send(input logic [31:0] v, input int n, input logic release_cs);
        cs_n = 1'b0;
        wait_clk(3);
        for (int i = n - 1; i >= 0; i--) begin
            db_i[0] = v[i];
            wait_clk(2);
            stb_sclk = 1'b1;
            wait_clk(3);
            stb_sclk = 1'b0;
            wait_clk(1);
        end
        wait_clk(6);
        if (release_cs) begin
            cs_n = 1'b1;
            wait_clk(6);
        end
    endtask

    task automatic t_reset;
        check("R2 reset oe_hi", db_oe_hi, 0);
        check("R2 reset oe_lo", db_oe_lo, 0);
        check("R12 reset idx_we", idx_we, 0);
        check("R12 reset ctl_we", ctl_we, 0);
        check("R6 reset rd_req", rd_req, 0);
    endtask

    task automatic t_enable_16;
        logic [15:0] d; logic oh, ol;
        set_mode(3'b000);
        bus_wr(1'b0, 16'h1234, 1'b0);
        check("R4 idx count", n_idx, 1);
        check("R3 idx word", last_w, 16'h1234);
        bus_wr(1'b1, 16'hBEEF, 1'b0);
        check("R3 ctl count", n_ctl, 1);
        check("R4 ctl word", last_w, 16'hBEEF);
        check("R12 idx unchanged", n_idx, 1);
        bus_rd(1'b0, 1'b0, d, oh, ol);
        check("R6 one request", n_rd, 1);
        check("R3 status word", d, STAT_VAL);
        check("R6 both lanes", {oh, ol}, 2'b11);
        check("R6 released", {db_oe_hi, db_oe_lo}, 2'b00);
        bus_rd(1'b1, 1'b0, d, oh, ol);
        check("R3 control read", d, CTL_VAL);
        check("R3 rd_rs high", rd_rs, 1);
    endtask

    task automatic t_dual_16;
        logic [15:0] d; logic oh, ol;
        set_mode(3'b010);
        bus_wr(1'b1, 16'hA55A, 1'b0);
        check("R5 ctl count", n_ctl, 2);
        check("R5 ctl word", last_w, 16'hA55A);
        bus_rd(1'b1, 1'b0, d, oh, ol);
        check("R5 read word", d, CTL_VAL);
        check("R5 read lanes", {oh, ol}, 2'b11);
        check("R5 read count", n_rd, 3);
    endtask

    task automatic t_cs_high;
        logic [15:0] d; logic oh, ol;
        set_mode(3'b010);
        bus_wr(1'b0, 16'h7777, 1'b1);
        check("R2 no write when deselected", n_idx, 1);
        bus_rd(1'b1, 1'b1, d, oh, ol);
        check("R2 no drive when deselected", {oh, ol}, 2'b00);
        check("R2 no request when deselected", n_rd, 3);
    endtask

    task automatic t_dual_8;
        logic [15:0] d; logic oh, ol;
        set_mode(3'b011);
        bus_wr(1'b0, 16'h12EE, 1'b0);
        check("R7 no pulse after first byte", n_idx, 1);
        bus_wr(1'b0, 16'h3499, 1'b0);
        check("R7 idx after pair", n_idx, 2);
        check("R7 byte order, low lanes ignored", last_w, 16'h1234);
        bus_rd(1'b1, 1'b0, d, oh, ol);
        check("R7 first read byte", d[15:8], CTL_VAL[15:8]);
        check("R7 first read lanes", {oh, ol}, 2'b10);
        bus_rd(1'b1, 1'b0, d, oh, ol);
        check("R7 second read byte", d[15:8], CTL_VAL[7:0]);
        check("R7 second read lanes", {oh, ol}, 2'b10);
        check("R7 one request per pair", n_rd, 4);
    endtask

    task automatic t_enable_8_restart;
        set_mode(3'b001);
        bus_wr(1'b1, 16'hAB00, 1'b0);
        bus_wr(1'b0, 16'h0000, 1'b0);
        check("R8 mismatch does not pair", n_ctl, 2);
        bus_wr(1'b0, 16'h0700, 1'b0);
        check("R8 idx after restart", n_idx, 3);
        check("R8 idx word", last_w, 16'h0007);
        check("R8 no stray ctl", n_ctl, 2);
        bus_wr(1'b1, 16'h1100, 1'b0);
        bus_wr(1'b1, 16'h2200, 1'b0);
        check("R8 first byte after index", last_w, 16'h1122);
        check("R8 ctl count", n_ctl, 3);
    endtask

    task automatic t_off_mode;
        logic [15:0] d; logic oh, ol;
        set_mode(3'b110);
        bus_wr(1'b0, 16'h4242, 1'b0);
        check("R1 disabled write", n_idx, 3);
        bus_rd(1'b0, 1'b0, d, oh, ol);
        check("R1 disabled drive", {oh, ol}, 2'b00);
        check("R1 disabled request", n_rd, 4);
    endtask

    task automatic t_serial;
        set_mode(3'b101);
        ser_send({8'h74, 16'hCAFE}, 24, 1'b1);
        check("R9 serial idx count", n_idx, 4);
        check("R9 serial word", last_w, 16'hCAFE);
        ser_send({8'h76, 16'h0102}, 24, 1'b0);
        check("R9 serial ctl word", last_w, 16'h0102);
        ser_send(32'h0304, 16, 1'b1);
        check("R11 burst count", n_ctl, 5);
        check("R11 burst word", last_w, 16'h0304);
        ser_send({8'h70, 16'h1111}, 24, 1'b1);
        check("R10 id mismatch idx", n_idx, 4);
        check("R10 id mismatch ctl", n_ctl, 5);
        ser_send({8'h75, 16'h2222}, 24, 1'b1);
        check("R10 read frame ignored", n_idx, 4);
        ser_send({8'h74, 8'hAB}, 16, 1'b1);
        check("R11 partial frame dropped", n_idx, 4);
        ser_send({8'h74, 16'h5555}, 24, 1'b1);
        check("R11 frame after abort", n_idx, 5);
        check("R11 word after abort", last_w, 16'h5555);
        check("R1 serial no request", n_rd, 4);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_enable_16();
        t_dual_16();
        t_cs_high();
        t_dual_8();
        t_enable_8_restart();
        t_off_mode();
        t_serial();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule